// File: doc/BRIEF.md
# Two-Way Write-Back Cache with Per-Set Way Prediction

This block is a small data cache that sits between a processor port and a block-granular memory port. It is organised as two ways per set, and each set keeps a one-bit guess of the way that will hit next. On a lookup the guessed way is examined first and its data is steered to the read port straight away. Only when that guess fails is the other way examined, one cycle later. A correct guess gives a response in the first cycle after the request is accepted. A wrong guess that still finds the block gives a response in the second cycle.

Stores that hit change only the cached line and mark it dirty. When a miss has to displace a dirty line, that line is first written to memory as a whole block. A clean or invalid slot is refilled directly. Each refill fetches the complete block that holds the missing word. The processor address is a word address. The lowest bits pick a word inside the line, the next bits pick the set (block address modulo the set count), and the remaining bits form the tag. Three counters report hits, misses and wrong guesses, so a user can measure how well the prediction works.

Top module: `wpc_cache`

## Requirements
- R1: With the default parameters, word address bits [1:0] select the word in a 4-word line, bits [4:2] select one of 8 sets (block address = address bits [15:2], set = block address mod 8), and bits [15:5] form the tag. A read always returns the most recently stored value of the addressed word.
- R2: A way hits only when its valid bit is set and its tag equals the request tag. At most one way of a set hits.
- R3: When the predicted way hits, resp_valid rises in the first cycle after the cycle in which req_valid and req_ready were both high. req_ready stays low from acceptance until the response.
- R4: When the predicted way misses and the other way hits, the response comes in the second cycle after acceptance, and cnt_mispred increments by one.
- R5: When both ways miss, the cache issues one read request (mem_req_we = 0) whose mem_req_blk is the full block address of the request. It answers one cycle after the cycle in which mem_rsp_valid delivers the line.
- R6: A store merges req_wdata into the word under req_be (bit i covers data bits 8i+7..8i) and issues no memory write on a hit. A displaced dirty line is written back (mem_req_we = 1, mem_req_blk = its own block address, mem_req_line = its current contents) before the refill read is issued.
- R7: The refill slot is way 0 if it is invalid, else way 1 if it is invalid, else the way that was not used most recently in that set.
- R8: After every hit or refill, the set's predictor points at the way that held the block, so an immediate repeat of the access hits in one cycle.
- R9: cnt_hit increments once for every access that hits in either way, cnt_miss once for every access that misses both ways, and cnt_mispred as stated in R4. All three counters start at zero.
- R10: After reset, req_ready is 1, resp_valid and mem_req_valid are 0, and every line is invalid, so the first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (16) | Word address |
| req_wdata | input | DATA_W (32) | Store data |
| req_be | input | WORD_BYTES (4) | Byte enables for a store |
| resp_valid | output | 1 | Access completes this cycle |
| resp_rdata | output | DATA_W (32) | Load data, valid with resp_valid on a load |
| mem_req_valid | output | 1 | Block request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write-back of a line, 0 = refill read |
| mem_req_blk | output | BLK_W (14) | Block address |
| mem_req_line | output | LINE_W (128) | Line data for a write-back |
| mem_rsp_valid | input | 1 | Refill line delivered |
| mem_rsp_line | input | LINE_W (128) | Refill line data |
| cnt_hit | output | CNT_W (16) | Accesses that hit |
| cnt_miss | output | CNT_W (16) | Accesses that missed |
| cnt_mispred | output | CNT_W (16) | Hits found only in the non-predicted way |

## Verification
The bench drives one set through a fixed sequence. A tag is first brought in, a second tag then fills the other way, and the first tag is read back so that the guess is wrong while the block is present. A design that forgot to retrain the predictor would show two-cycle latency on repeats, and one that counted this case as a miss would fetch from memory. A partial store is followed by two conflicting misses, so the stored line becomes the least recently used dirty victim. A design that evicted the recently used way, skipped the write-back, issued the refill first or wrote back stale bytes would give a wrong block address, a wrong line image or wrong data on the later re-read. A long run of mixed loads and partial stores over four tags that collide in two sets then compares latency, data, memory traffic and counters against a behavioural model on every access.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    parameter int ADDR_W     = 16;
    parameter int DATA_W     = 32;
    parameter int LINE_WORDS = 4;
    parameter int SETS       = 8;
    parameter int CNT_W      = 16;

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WIDX_W     = $clog2(LINE_WORDS);
    localparam int SET_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - SET_W - WIDX_W;
    localparam int BLK_W      = TAG_W + SET_W;
    localparam int LINE_W     = LINE_WORDS * DATA_W;

    typedef logic [DATA_W-1:0]                  word_t;
    typedef logic [LINE_WORDS-1:0][DATA_W-1:0]  line_t;
    typedef logic [TAG_W-1:0]                   tag_t;
    typedef logic [SET_W-1:0]                   set_t;
    typedef logic [WIDX_W-1:0]                  widx_t;
    typedef logic [WORD_BYTES-1:0]              be_t;

    typedef struct packed {
        tag_t  tag;
        set_t  set;
        widx_t widx;
    } addr_t;

    typedef struct packed {
        logic  write;
        addr_t addr;
        word_t wdata;
        be_t   be;
    } req_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRED, ST_ALT, ST_EVICT, ST_FETCH, ST_FILL, ST_REPLY
    } state_t;

    function automatic word_t merge_bytes(word_t old_w, word_t new_w, be_t be);
        word_t r;
        r = old_w;
        for (int b = 0; b < WORD_BYTES; b++)
            if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
        return r;
    endfunction
endpackage

// File: rtl/wpc_meta.sv
module wpc_meta
    import wpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  set_t             set_i,
    input  tag_t             tag_i,
    output logic [1:0]       way_hit,
    output logic [1:0]       way_valid,
    output logic [1:0]       way_dirty,
    output logic [1:0][TAG_W-1:0] way_tag,
    output logic             pred_o,
    output logic             mru_o,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             touch_dirty
);
    logic [1:0] vld   [SETS];
    logic [1:0] dty   [SETS];
    tag_t       tags  [SETS][2];
    logic       pred  [SETS];
    logic       mru   [SETS];

    for (genvar g = 0; g < 2; g++) begin : g_way
        assign way_valid[g] = vld[set_i][g];
        assign way_dirty[g] = dty[set_i][g];
        assign way_tag[g]   = tags[set_i][g];
        assign way_hit[g]   = vld[set_i][g] && (tags[set_i][g] == tag_i);
    end

    assign pred_o = pred[set_i];
    assign mru_o  = mru[set_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s]  <= '0;
                dty[s]  <= '0;
                pred[s] <= 1'b0;
                mru[s]  <= 1'b0;
            end
        end else begin
            if (fill_en) begin
                vld[set_i][fill_way] <= 1'b1;
                dty[set_i][fill_way] <= 1'b0;
            end
            if (touch_en) begin
                pred[set_i] <= touch_way;
                mru[set_i]  <= touch_way;
                if (touch_dirty) dty[set_i][touch_way] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tags[set_i][fill_way] <= tag_i;
    end

    // R2: a tag is installed only after both ways missed, so two ways never match
    a_r2_single_hit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));
endmodule

// File: rtl/wpc_data.sv
module wpc_data
    import wpc_pkg::*;
(
    input  logic  clk,
    input  set_t  set_i,
    input  logic  rd_way,
    output line_t rd_line,
    input  logic  fill_en,
    input  logic  fill_way,
    input  line_t fill_line,
    input  logic  wr_en,
    input  logic  wr_way,
    input  widx_t wr_widx,
    input  word_t wr_data,
    input  be_t   wr_be
);
    line_t lines [SETS][2];

    assign rd_line = lines[set_i][rd_way];

    always_ff @(posedge clk) begin
        if (fill_en)
            lines[set_i][fill_way] <= fill_line;
        else if (wr_en)
            lines[set_i][wr_way][wr_widx] <=
                merge_bytes(lines[set_i][wr_way][wr_widx], wr_data, wr_be);
    end
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
    import wpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WORD_BYTES-1:0] req_be,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [BLK_W-1:0]  mem_req_blk,
    output logic [LINE_W-1:0] mem_req_line,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_line,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_mispred
);
    state_t st;
    req_t   rq;
    logic   vict_q;

    logic [1:0]            way_hit, way_valid, way_dirty;
    logic [1:0][TAG_W-1:0] way_tag;
    logic                  pred_w, mru_w;
    logic                  cur_way, look_hit, victim_c, fill_now;
    line_t                 rd_line;

    always_comb begin
        case (st)
            ST_PRED: cur_way = pred_w;
            ST_ALT:  cur_way = ~pred_w;
            default: cur_way = vict_q;
        endcase
    end

    assign look_hit = way_hit[cur_way];
    assign victim_c = !way_valid[0] ? 1'b0 : (!way_valid[1] ? 1'b1 : ~mru_w);
    assign fill_now = (st == ST_FILL) && mem_rsp_valid;

    assign req_ready  = (st == ST_IDLE);
    assign resp_valid = ((st == ST_PRED || st == ST_ALT) && look_hit) || (st == ST_REPLY);
    assign resp_rdata = rd_line[rq.addr.widx];

    assign mem_req_valid = (st == ST_EVICT) || (st == ST_FETCH);
    assign mem_req_we    = (st == ST_EVICT);
    assign mem_req_blk   = {(st == ST_EVICT) ? way_tag[vict_q] : rq.addr.tag, rq.addr.set};
    assign mem_req_line  = rd_line;

    wpc_meta u_meta (
        .clk        (clk),
        .rst        (rst),
        .set_i      (rq.addr.set),
        .tag_i      (rq.addr.tag),
        .way_hit    (way_hit),
        .way_valid  (way_valid),
        .way_dirty  (way_dirty),
        .way_tag    (way_tag),
        .pred_o     (pred_w),
        .mru_o      (mru_w),
        .fill_en    (fill_now),
        .fill_way   (vict_q),
        .touch_en   (resp_valid),
        .touch_way  (cur_way),
        .touch_dirty(resp_valid && rq.write)
    );

    wpc_data u_data (
        .clk      (clk),
        .set_i    (rq.addr.set),
        .rd_way   (cur_way),
        .rd_line  (rd_line),
        .fill_en  (fill_now),
        .fill_way (vict_q),
        .fill_line(line_t'(mem_rsp_line)),
        .wr_en    (resp_valid && rq.write),
        .wr_way   (cur_way),
        .wr_widx  (rq.addr.widx),
        .wr_data  (rq.wdata),
        .wr_be    (rq.be)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            rq          <= '0;
            vict_q      <= 1'b0;
            cnt_hit     <= '0;
            cnt_miss    <= '0;
            cnt_mispred <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    rq <= '{write: req_write, addr: addr_t'(req_addr),
                            wdata: req_wdata, be: req_be};
                    st <= ST_PRED;
                end
                ST_PRED: begin
                    if (look_hit) begin
                        cnt_hit <= cnt_hit + CNT_W'(1);
                        st      <= ST_IDLE;
                    end else begin
                        st <= ST_ALT;
                    end
                end
                ST_ALT: begin
                    if (look_hit) begin
                        cnt_hit     <= cnt_hit + CNT_W'(1);
                        cnt_mispred <= cnt_mispred + CNT_W'(1);
                        st          <= ST_IDLE;
                    end else begin
                        cnt_miss <= cnt_miss + CNT_W'(1);
                        vict_q   <= victim_c;
                        st <= (way_valid[victim_c] && way_dirty[victim_c]) ? ST_EVICT : ST_FETCH;
                    end
                end
                ST_EVICT: if (mem_req_ready) st <= ST_FETCH;
                ST_FETCH: if (mem_req_ready) st <= ST_FILL;
                ST_FILL:  if (mem_rsp_valid) st <= ST_REPLY;
                ST_REPLY: st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // R3: once a request is taken, no second one is taken before the reply
    a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R6: a write-back is followed straight away by the refill read
    a_r6_wb_then_fetch: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we && mem_req_ready) |=> (mem_req_valid && !mem_req_we));

    // R6: only a valid dirty line is ever written back
    a_r6_wb_dirty_only: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we) |-> (way_valid[vict_q] && way_dirty[vict_q]));

    // R5: the reply follows the cycle that delivered the refill line
    a_r5_reply_after_fill: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_FILL) && mem_rsp_valid) |=> resp_valid);

    // R9: the hit count moves only in a cycle that completed an access
    a_r9_hit_count_moves_on_reply: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |=> $stable(cnt_hit));
endmodule

// File: tb/wpc_cache_bench.sv
`timescale 1ns/1ps
module wpc_cache_bench;
    import wpc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [WORD_BYTES-1:0] req_be = '0;
    logic              req_ready, resp_valid;
    logic [DATA_W-1:0] resp_rdata;
    logic              mem_req_valid, mem_req_we;
    logic              mem_req_ready = 1'b1;
    logic [BLK_W-1:0]  mem_req_blk;
    logic [LINE_W-1:0] mem_req_line;
    logic              mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_line = '0;
    logic [CNT_W-1:0]  cnt_hit, cnt_miss, cnt_mispred;

    wpc_cache u_wpc_cache (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    // golden word memory and backing block memory
    logic [DATA_W-1:0] gold [int];
    line_t             bmem [int];

    function automatic logic [DATA_W-1:0] pat(int a);
        return DATA_W'(a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction
    function automatic logic [DATA_W-1:0] gw(int a);
        return gold.exists(a) ? gold[a] : pat(a);
    endfunction
    function automatic line_t bline(int blk);
        line_t l;
        if (bmem.exists(blk)) return bmem[blk];
        for (int i = 0; i < LINE_WORDS; i++) l[i] = pat(blk * LINE_WORDS + i);
        return l;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder, acts away from the rising edge
    int wb_seen = 0, rd_seen = 0, last_wb_blk = -1, last_rd_blk = -1;
    bit pend = 0;
    int pend_blk = 0;
    bit wb_ok = 1;
    always @(negedge clk) begin
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_line  = bline(pend_blk);
            pend = 0;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        if (!rst && mem_req_valid) begin
            if (mem_req_we) begin
                line_t l;
                l = line_t'(mem_req_line);
                wb_seen++;
                last_wb_blk = int'(mem_req_blk);
                for (int i = 0; i < LINE_WORDS; i++)
                    if (l[i] !== gw(last_wb_blk * LINE_WORDS + i)) wb_ok = 0;
                bmem[last_wb_blk] = l;
            end else begin
                rd_seen++;
                last_rd_blk = int'(mem_req_blk);
                pend = 1;
                pend_blk = last_rd_blk;
            end
        end
    end

    // behavioural reference state
    int  m_tag [SETS][2];
    bit  m_vld [SETS][2];
    bit  m_dty [SETS][2];
    bit  m_pred [SETS];
    bit  m_mru  [SETS];
    int  e_hit = 0, e_miss = 0, e_mp = 0, e_wb = 0, e_rd = 0;

    task automatic acc(bit wr, int addr, logic [DATA_W-1:0] wd, logic [WORD_BYTES-1:0] be);
        int s, t, blk, p, o, w, v, lat, e_wb_blk;
        string ltag;
        logic [DATA_W-1:0] exp_d;
        bit lat_ok, rdy_ok;
        s   = (addr / LINE_WORDS) % SETS;
        t   = addr / (LINE_WORDS * SETS);
        blk = addr / LINE_WORDS;
        p = m_pred[s]; o = 1 - p; e_wb_blk = -1;
        if (m_vld[s][p] && m_tag[s][p] == t) begin
            lat = 1; w = p; ltag = "R3/R8"; e_hit++;
        end else if (m_vld[s][o] && m_tag[s][o] == t) begin
            lat = 2; w = o; ltag = "R2/R4"; e_hit++; e_mp++;
        end else begin
            v = !m_vld[s][0] ? 0 : (!m_vld[s][1] ? 1 : 1 - m_mru[s]);
            if (m_vld[s][v] && m_dty[s][v]) begin
                lat = 6; e_wb++; e_wb_blk = m_tag[s][v] * SETS + s; ltag = "R6/R7";
            end else begin
                lat = 5; ltag = "R5/R7";
            end
            e_miss++; e_rd++;
            m_vld[s][v] = 1; m_tag[s][v] = t; m_dty[s][v] = 0; w = v;
        end
        m_pred[s] = w[0]; m_mru[s] = w[0];
        if (wr) m_dty[s][w] = 1;
        exp_d = gw(addr);

        req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr);
        req_wdata = wd; req_be = be;
        @(posedge clk);
        lat_ok = 1; rdy_ok = 1;
        for (int c = 1; c <= lat; c++) begin
            @(negedge clk);
            if (c == 1) req_valid = 1'b0;
            if (resp_valid !== (c == lat)) lat_ok = 0;
            if (req_ready !== 1'b0) rdy_ok = 0;
        end
        check(lat_ok, ltag, "response latency", lat, lat);
        check(rdy_ok, "R3", "req_ready low while busy", req_ready, 0);
        if (!wr) check(resp_rdata === exp_d, "R1", "load data", resp_rdata, exp_d);
        if (wr) gold[addr] = merge_bytes(gw(addr), wd, be);
        @(negedge clk);
        check(cnt_hit == CNT_W'(e_hit), "R9", "cnt_hit", cnt_hit, e_hit);
        check(cnt_miss == CNT_W'(e_miss), "R9", "cnt_miss", cnt_miss, e_miss);
        check(cnt_mispred == CNT_W'(e_mp), "R4", "cnt_mispred", cnt_mispred, e_mp);
        check(wb_seen == e_wb, "R6", "write-back count", wb_seen, e_wb);
        check(rd_seen == e_rd, "R5", "refill read count", rd_seen, e_rd);
        if (lat >= 5) check(last_rd_blk == blk, "R5", "refill block address", last_rd_blk, blk);
        if (lat == 6) begin
            check(last_wb_blk == e_wb_blk, "R7", "victim block address", last_wb_blk, e_wb_blk);
            check(wb_ok, "R6", "write-back line contents", wb_ok, 1);
        end
    endtask

    function automatic int mk(int tag, int set, int widx);
        return (tag * SETS + set) * LINE_WORDS + widx;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R10: idle outputs and zero counters after reset
        check(req_ready === 1'b1, "R10", "req_ready after reset", req_ready, 1);
        check(resp_valid === 1'b0, "R10", "resp_valid after reset", resp_valid, 0);
        check(mem_req_valid === 1'b0, "R10", "mem_req_valid after reset", mem_req_valid, 0);
        check(cnt_hit == 0 && cnt_miss == 0 && cnt_mispred == 0, "R10", "counters after reset",
              cnt_hit, 0);

        acc(0, mk(1, 0, 2), 0, 0);           // R10 first access misses, R5 clean refill
        acc(0, mk(1, 0, 2), 0, 0);           // R8 repeat hits in predicted way
        acc(0, mk(2, 0, 1), 0, 0);           // R7 invalid way 1 is filled
        acc(0, mk(1, 0, 3), 0, 0);           // R4 wrong guess, block in way 0
        acc(1, mk(1, 0, 3), 32'hDEADBEEF, 4'b0101); // R6 partial store hit, no memory write
        acc(0, mk(1, 0, 3), 0, 0);           // R6 merged bytes read back
        acc(0, mk(3, 0, 0), 0, 0);           // R7 clean way 1 displaced
        acc(0, mk(4, 0, 0), 0, 0);           // R6 dirty way 0 written back first
        acc(0, mk(1, 0, 3), 0, 0);           // R1 data survives the round trip
        acc(0, mk(1, 5, 0), 0, 0);           // R1 other set is independent

        for (int k = 0; k < 400; k++) begin
            int a;
            bit wr;
            a  = mk($urandom_range(0, 3), $urandom_range(0, 1) * 3, $urandom_range(0, 3));
            wr = ($urandom_range(0, 2) == 0);
            acc(wr, a, $urandom, WORD_BYTES'($urandom_range(1, 15)));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule